// File: doc/BRIEF.md
# Timer Compare Unit with Period Trigger

This block pairs a 16-bit up-counting timer with a 16-bit compare register and a small control state machine. The timer advances by one on each clock edge where both its run enable and its synchronous count strobe are high. The compare register is checked against the timer value continuously. When the two become equal, the action chosen by a 4-bit mode code is carried out exactly once for that timer value. The action can be to set the output latch, to clear it, to raise only the compare interrupt flag, or to fire a period trigger. The period trigger zeroes the timer and sends a one-cycle conversion-start request.

In trigger mode the compare register sets the timer's period: the timer runs from 0 up to the compare value and then starts again at 0. Two sticky interrupt flags are kept, one for compare events and one for natural timer rollover. Each flag has its own clear input. The output latch drives the pin only while the output-enable input is high.

The control state machine has three states. ST_OFF means compare is disabled. ST_ARMED means it waits for equality. ST_HIT means equality has already been acted on. The transitions are: ST_OFF to ST_ARMED when a valid mode code is stored; ST_ARMED to ST_HIT on the match event; ST_HIT to ST_ARMED when the timer no longer equals the compare value; and from ST_ARMED or ST_HIT back to ST_OFF whenever the stored mode code is not a valid one.

Top module: `cmp_timer_unit`

## Requirements
- R1: The timer increments by one on each rising edge where `tmr_en` and `tmr_tick` are both 1. Otherwise it holds, unless it is cleared by the period trigger (R5).
- R2: With mode 4'b1000 the output latch goes to 1, and with mode 4'b1001 it goes to 0. In both cases the change appears on the edge after the first cycle in which the timer equals the compare value.
- R3: Every acted match sets `cmp_flag` on the following edge, in each of the four valid modes.
- R4: With mode 4'b1010 a match leaves the output latch unchanged and only sets `cmp_flag`.
- R5: With mode 4'b1011 a match clears the timer to 0 on the next edge, and this clear takes priority over counting. `go_req` is 1 for exactly that one cycle, so the match repeats every compare value + 1 counts.
- R6: `ovf_flag` is set only when the timer counts from 16'hFFFF to 16'h0000 by itself. A clear caused by the period trigger never sets it, even when the compare value is 16'hFFFF.
- R7: Writing mode 4'b0000 forces the output latch low on the write edge. Any mode code other than 4'b1000 to 4'b1011 disables compare: a match then sets no flag and leaves the latch unchanged.
- R8: A match is acted on once per timer value. If the timer is held at the compare value, no further flag set or latch action occurs.
- R9: Both flags stay set until their clear input is 1 at an edge. When a set and a clear arrive at the same edge, the flag ends up set.
- R10: `pin_out` equals the output latch while `out_en` is 1 and is 0 otherwise. `pin_oe` follows `out_en`.
- R11: After reset the timer is 0, the latch is low, both flags and `go_req` are 0, and compare is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Timer run enable |
| tmr_tick | input | 1 | Synchronous count strobe |
| cmp_we | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | 16 | New compare value |
| mode_we | input | 1 | Write strobe for the mode code |
| mode_wdata | input | 4 | New mode code |
| out_en | input | 1 | Pin direction: 1 drives the pin |
| pin_out | output | 1 | Compare output pin |
| pin_oe | output | 1 | Pin output enable |
| cmp_flag | output | 1 | Sticky compare interrupt flag |
| cmp_flag_clr | input | 1 | Clears `cmp_flag` |
| ovf_flag | output | 1 | Sticky timer rollover flag |
| ovf_flag_clr | input | 1 | Clears `ovf_flag` |
| go_req | output | 1 | One-cycle conversion-start request |
| tmr_value | output | 16 | Current timer value |

## Verification
The bench holds the timer at the compare value to show that the action is taken once per value; a design that re-fired on every equal cycle would set the flag again right after it was cleared. It fires the period trigger at a compare value of 16'hFFFF to show that this clear is kept apart from a natural rollover; a design that used the wrap condition alone would set the rollover flag there. It also applies a set and a clear to a flag in the same cycle, where a design with clear priority would lose the event. Finally it checks that an unused mode code neither sets the flag nor moves the latch, while the all-zero code forces the latch low at once.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int unsigned MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF  = 4'b0000,
        MODE_HI   = 4'b1000,
        MODE_LO   = 4'b1001,
        MODE_IRQ  = 4'b1010,
        MODE_TRIG = 4'b1011
    } cmp_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARMED,
        ST_HIT
    } cmp_state_e;

    localparam int unsigned FLAG_CMP = 0;
    localparam int unsigned FLAG_OVF = 1;
    localparam int unsigned FLAG_N   = 2;

    function automatic logic mode_active(input logic [MODE_W-1:0] m);
        return (m == MODE_HI) || (m == MODE_LO) || (m == MODE_IRQ) || (m == MODE_TRIG);
    endfunction

endpackage

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             zero_req,
    output logic [WIDTH-1:0] value,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] TOP = '1;

    logic step;
    assign step = run && tick;

    // natural rollover only; a trigger clear suppresses it
    assign wrap = step && !zero_req && (value == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (zero_req) begin
            value <= '0;
        end else if (step) begin
            value <= value + WIDTH'(1);
        end
    end
endmodule

// File: rtl/cmp_sticky_flag.sv
module cmp_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/cmp_match_ctrl.sv
module cmp_match_ctrl
    import cmp_timer_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  tmr,
    input  logic              cmp_we,
    input  logic [WIDTH-1:0]  cmp_wdata,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic              hit,
    output logic              trig_zero,
    output logic              latch_q,
    output logic              go_q
);
    logic [WIDTH-1:0]  cmp_q;
    logic [MODE_W-1:0] mode_q;
    cmp_state_e        state_q;
    cmp_state_e        state_d;
    logic              match;
    logic              active;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= MODE_OFF;
        end else begin
            if (cmp_we) begin
                cmp_q <= cmp_wdata;
            end
            if (mode_we) begin
                mode_q <= mode_wdata;
            end
        end
    end

    assign match  = (tmr == cmp_q);
    assign active = mode_active(mode_q);

    // match event: first equal cycle while armed
    assign hit       = (state_q == ST_ARMED) && active && match;
    assign trig_zero = hit && (mode_q == MODE_TRIG);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (active) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!active) begin
                    state_d = ST_OFF;
                end else if (match) begin
                    state_d = ST_HIT;
                end
            end
            ST_HIT: begin
                if (!active) begin
                    state_d = ST_OFF;
                end else if (!match) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: latch and conversion request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
            go_q    <= 1'b0;
        end else begin
            go_q <= trig_zero;
            if (mode_we && (mode_wdata == MODE_OFF)) begin
                latch_q <= 1'b0;
            end else if (hit) begin
                case (mode_q)
                    MODE_HI: latch_q <= 1'b1;
                    MODE_LO: latch_q <= 1'b0;
                    default: latch_q <= latch_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
    import cmp_timer_pkg::*;
#(
    parameter int unsigned TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_en,
    input  logic              tmr_tick,
    input  logic              cmp_we,
    input  logic [TMR_W-1:0]  cmp_wdata,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              out_en,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              cmp_flag,
    input  logic              cmp_flag_clr,
    output logic              ovf_flag,
    input  logic              ovf_flag_clr,
    output logic              go_req,
    output logic [TMR_W-1:0]  tmr_value
);
    logic              hit;
    logic              trig_zero;
    logic              wrap;
    logic              latch_q;
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flag_clr;
    logic [FLAG_N-1:0] flag_q;

    cmp_timer_count #(.WIDTH(TMR_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_en),
        .tick     (tmr_tick),
        .zero_req (trig_zero),
        .value    (tmr_value),
        .wrap     (wrap)
    );

    cmp_match_ctrl #(.WIDTH(TMR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr        (tmr_value),
        .cmp_we     (cmp_we),
        .cmp_wdata  (cmp_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .hit        (hit),
        .trig_zero  (trig_zero),
        .latch_q    (latch_q),
        .go_q       (go_req)
    );

    assign flag_set[FLAG_CMP] = hit;
    assign flag_clr[FLAG_CMP] = cmp_flag_clr;
    assign flag_set[FLAG_OVF] = wrap;
    assign flag_clr[FLAG_OVF] = ovf_flag_clr;

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        cmp_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set[g]),
            .clr   (flag_clr[g]),
            .flag  (flag_q[g])
        );
    end

    assign cmp_flag = flag_q[FLAG_CMP];
    assign ovf_flag = flag_q[FLAG_OVF];
    assign pin_oe   = out_en;
    assign pin_out  = out_en && latch_q;
endmodule

// File: rtl/cmp_timer_unit_chk.sv
module cmp_timer_unit_chk #(
    parameter int unsigned TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_en,
    input logic             tmr_tick,
    input logic             mode_we,
    input logic [3:0]       mode_wdata,
    input logic             out_en,
    input logic             pin_out,
    input logic             cmp_flag,
    input logic             cmp_flag_clr,
    input logic             ovf_flag,
    input logic             go_req,
    input logic [TMR_W-1:0] tmr_value
);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en || !tmr_tick) |=> (tmr_value == $past(tmr_value) || go_req));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && tmr_tick) |=> (tmr_value == $past(tmr_value) + TMR_W'(1) || go_req));

    p_go_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        go_req |=> !go_req);

    p_go_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        go_req |-> (tmr_value == '0));

    p_ovf_natural_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (tmr_value == '0 && $past(tmr_value) == '1 && !go_req));

    p_mode_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_wdata == 4'b0000) |=> !pin_out);

    p_cmp_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !cmp_flag_clr) |=> cmp_flag);

    p_quiet_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !pin_out);
endmodule

bind cmp_timer_unit cmp_timer_unit_chk #(.TMR_W(TMR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmr_en       (tmr_en),
    .tmr_tick     (tmr_tick),
    .mode_we      (mode_we),
    .mode_wdata   (mode_wdata),
    .out_en       (out_en),
    .pin_out      (pin_out),
    .cmp_flag     (cmp_flag),
    .cmp_flag_clr (cmp_flag_clr),
    .ovf_flag     (ovf_flag),
    .go_req       (go_req),
    .tmr_value    (tmr_value)
);

// File: tb/test_cmp_timer_unit.sv
module test_cmp_timer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0;
    logic        tmr_tick = 1'b0;
    logic        cmp_we = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic        mode_we = 1'b0;
    logic [3:0]  mode_wdata = '0;
    logic        out_en = 1'b0;
    logic        pin_out;
    logic        pin_oe;
    logic        cmp_flag;
    logic        cmp_flag_clr = 1'b0;
    logic        ovf_flag;
    logic        ovf_flag_clr = 1'b0;
    logic        go_req;
    logic [15:0] tmr_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cmp_timer_unit i_cmp_timer_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmr_en       (tmr_en),
        .tmr_tick     (tmr_tick),
        .cmp_we       (cmp_we),
        .cmp_wdata    (cmp_wdata),
        .mode_we      (mode_we),
        .mode_wdata   (mode_wdata),
        .out_en       (out_en),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .cmp_flag     (cmp_flag),
        .cmp_flag_clr (cmp_flag_clr),
        .ovf_flag     (ovf_flag),
        .ovf_flag_clr (ovf_flag_clr),
        .go_req       (go_req),
        .tmr_value    (tmr_value)
    );

    always #5 clk = ~clk;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [15:0] c, input logic [3:0] m);
        @(negedge clk);
        cmp_we = 1'b1; cmp_wdata = c;
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        cmp_we = 1'b0; mode_we = 1'b0;
    endtask

    task automatic wait_val(input logic [15:0] v);
        int n = 0;
        while (tmr_value !== v && n < 70000) begin
            @(negedge clk);
            n++;
        end
        if (tmr_value !== v) chk("timer reach target", 32'(tmr_value), 32'(v));
    endtask

    task automatic clr_cmp();
        @(negedge clk); cmp_flag_clr = 1'b1;
        @(negedge clk); cmp_flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 timer", 32'(tmr_value), 0);
        chk("R11 pin", 32'(pin_out), 0);
        chk("R11 cmp flag", 32'(cmp_flag), 0);
        chk("R11 ovf flag", 32'(ovf_flag), 0);
        chk("R11 go", 32'(go_req), 0);
    endtask

    task automatic t_count();
        logic [15:0] base;
        @(negedge clk); tmr_en = 1'b1; tmr_tick = 1'b0;
        base = tmr_value;
        repeat (3) @(negedge clk);
        chk("R1 hold without tick", 32'(tmr_value), 32'(base));
        tmr_en = 1'b0; tmr_tick = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 hold without enable", 32'(tmr_value), 32'(base));
        tmr_en = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 count by one", 32'(tmr_value), 32'(base + 16'd5));
    endtask

    task automatic t_set_high();
        logic [15:0] c;
        out_en = 1'b1;
        c = tmr_value + 16'd20;
        set_cfg(c, 4'b1000);
        chk("R2 pin low before match", 32'(pin_out), 0);
        wait_val(c);
        @(negedge clk);
        chk("R2 set high", 32'(pin_out), 1);
        chk("R3 flag on set-high", 32'(cmp_flag), 1);
        clr_cmp();
        chk("R9 flag cleared", 32'(cmp_flag), 0);
    endtask

    task automatic t_once();
        logic [15:0] c;
        c = tmr_value + 16'd20;
        set_cfg(c, 4'b1000);
        wait_val(c);
        tmr_tick = 1'b0;
        @(negedge clk);
        chk("R8 first action", 32'(cmp_flag), 1);
        clr_cmp();
        repeat (4) @(negedge clk);
        chk("R8 no repeat while held", 32'(cmp_flag), 0);
        chk("R8 timer still at compare", 32'(tmr_value), 32'(c));
        tmr_tick = 1'b1;
    endtask

    task automatic t_clear_low();
        logic [15:0] c;
        c = tmr_value + 16'd20;
        set_cfg(c, 4'b1001);
        chk("R2 pin high before clear", 32'(pin_out), 1);
        wait_val(c);
        @(negedge clk);
        chk("R2 clear low", 32'(pin_out), 0);
        chk("R3 flag on clear-low", 32'(cmp_flag), 1);
        clr_cmp();
    endtask

    task automatic t_soft();
        logic [15:0] c;
        c = tmr_value + 16'd20;
        set_cfg(c, 4'b1000);
        wait_val(c);
        @(negedge clk);
        clr_cmp();
        c = tmr_value + 16'd20;
        set_cfg(c, 4'b1010);
        wait_val(c);
        @(negedge clk);
        chk("R4 pin unchanged", 32'(pin_out), 1);
        chk("R4 R3 flag only", 32'(cmp_flag), 1);
        clr_cmp();
    endtask

    task automatic t_oe();
        @(negedge clk); out_en = 1'b0;
        #1;
        chk("R10 pin quiet", 32'(pin_out), 0);
        chk("R10 oe low", 32'(pin_oe), 0);
        @(negedge clk); out_en = 1'b1;
        #1;
        chk("R10 pin follows latch", 32'(pin_out), 1);
        chk("R10 oe high", 32'(pin_oe), 1);
    endtask

    task automatic t_invalid();
        logic [15:0] c;
        c = tmr_value + 16'd20;
        set_cfg(c, 4'b0101);
        wait_val(c);
        @(negedge clk);
        chk("R7 unused code no flag", 32'(cmp_flag), 0);
        chk("R7 unused code keeps latch", 32'(pin_out), 1);
        mode_we = 1'b1; mode_wdata = 4'b0000;
        @(negedge clk);
        mode_we = 1'b0;
        chk("R7 zero code forces low", 32'(pin_out), 0);
    endtask

    task automatic t_set_wins();
        logic [15:0] c;
        c = tmr_value + 16'd20;
        set_cfg(c, 4'b1000);
        wait_val(c);
        cmp_flag_clr = 1'b1;
        @(negedge clk);
        chk("R9 set wins over clear", 32'(cmp_flag), 1);
        @(negedge clk);
        chk("R9 later clear", 32'(cmp_flag), 0);
        cmp_flag_clr = 1'b0;
    endtask

    task automatic t_trigger();
        logic [15:0] c;
        c = tmr_value + 16'd20;
        set_cfg(c, 4'b1011);
        wait_val(c);
        @(negedge clk);
        chk("R5 timer cleared", 32'(tmr_value), 0);
        chk("R5 go pulse", 32'(go_req), 1);
        chk("R3 flag on trigger", 32'(cmp_flag), 1);
        chk("R6 no overflow from trigger", 32'(ovf_flag), 0);
        @(negedge clk);
        chk("R5 go one cycle", 32'(go_req), 0);
        repeat (int'(c) - 1) @(negedge clk);
        chk("R5 no go before period", 32'(go_req), 0);
        @(negedge clk);
        chk("R5 period repeat", 32'(go_req), 1);
        chk("R5 period timer zero", 32'(tmr_value), 0);
        set_cfg(16'd0, 4'b0000);
        clr_cmp();
    endtask

    task automatic t_overflow();
        wait_val(16'hFFFF);
        @(negedge clk);
        chk("R6 natural wrap to zero", 32'(tmr_value), 0);
        chk("R6 overflow flag set", 32'(ovf_flag), 1);
        @(negedge clk); ovf_flag_clr = 1'b1;
        @(negedge clk); ovf_flag_clr = 1'b0;
        chk("R9 overflow cleared", 32'(ovf_flag), 0);
    endtask

    task automatic t_trig_top();
        set_cfg(16'hFFFF, 4'b1011);
        wait_val(16'hFFFF);
        @(negedge clk);
        chk("R5 top trigger clears", 32'(tmr_value), 0);
        chk("R5 top trigger go", 32'(go_req), 1);
        chk("R6 top trigger no overflow", 32'(ovf_flag), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_count();
        t_set_high();
        t_once();
        t_clear_low();
        t_soft();
        t_oe();
        t_invalid();
        t_set_wins();
        t_trigger();
        t_overflow();
        t_trig_top();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule